// File: doc/BRIEF.md
# Segment Containment and Descriptor Builder

This unit prepares the two thread-local segment registers (FS and GS) when a thread resumes inside a protected execution region. In 32-bit mode it adds each per-thread offset to the region's base address to form the segment base. It adds the per-thread limit to obtain the last byte of the segment. It then confirms that the resulting span sits inside the current data segment. A span whose last byte falls below its base has wrapped around the 32-bit space. Such a span is accepted only when the data segment reaches the full 4 GiB.

In 64-bit mode no span is formed. The two bases come straight from the thread's saved register area, and the only check is that both are canonical addresses. When a request passes its checks, the unit loads two complete hidden descriptors. Their type, flags and selector are fixed values, and four attribute fields are copied from the data segment. A request strobe is answered one clock later with a result strobe, a fault flag and the descriptor registers.

Top module: `seg_desc_builder`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high, and low otherwise; `fault` and the descriptor outputs change only on those cycles.
- R2: In 32-bit mode (`mode64`=0) each base is `ofs + encl_base` modulo 2^32, zero-extended to 64 bits on `fs_base`/`gs_base`. The carry out of the addition is never a fault source.
- R3: In 32-bit mode, let end = base + limit modulo 2^32. When end >= base, a segment faults if end is greater than `ds_limit`. An end exactly equal to `ds_limit` is accepted.
- R4: In 32-bit mode, when end < base (wrap-around), a segment faults unless `ds_limit` equals 32'hFFFF_FFFF.
- R5: In 64-bit mode the bases are `fs_base64`/`gs_base64` unchanged. The result faults when either base is not canonical, meaning bits 63 down to 47 are not all equal.
- R6: `fault` is the OR of the FS and GS checks of the accepted request. In 64-bit mode the offsets, the limits and `ds_limit` have no effect on it. In 32-bit mode `fs_base64`/`gs_base64` have no effect on any output.
- R7: On a result without fault, `fs_limit`/`gs_limit` take the per-thread limit inputs `fs_lim`/`gs_lim`.
- R8: On a result without fault, each attribute word has a fixed part: [3:0] type = 4'b0001, [5] S = 1, [8] P = 1, [11] B = 1, [12] G = 1 and [13] unusable = 0. Each selector output becomes 16'h000B.
- R9: On a result without fault, attribute bits are copied from the data segment: [4] W from `ds_w`, [7:6] DPL from `ds_dpl`, [9] AVL from `ds_avl` and [10] L from `ds_l`.
- R10: On a faulting result, all descriptor outputs (bases, limits, attributes, selectors) keep their previous values.
- R11: After reset, `out_valid` and `fault` are 0 and all descriptor outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| encl_base | input | 32 | Protected region base address (32-bit mode) |
| fs_ofs | input | 32 | FS offset from region base |
| gs_ofs | input | 32 | GS offset from region base |
| fs_lim | input | 32 | FS per-thread limit |
| gs_lim | input | 32 | GS per-thread limit |
| ds_limit | input | 32 | Current data segment limit |
| ds_w | input | 1 | Data segment writable flag |
| ds_dpl | input | 2 | Data segment privilege level |
| ds_avl | input | 1 | Data segment available bit |
| ds_l | input | 1 | Data segment long-mode bit |
| fs_base64 | input | 64 | Saved FS base (64-bit mode) |
| gs_base64 | input | 64 | Saved GS base (64-bit mode) |
| out_valid | output | 1 | Result strobe |
| fault | output | 1 | Containment or canonical fault of last result |
| fs_base | output | 64 | Loaded FS base |
| gs_base | output | 64 | Loaded GS base |
| fs_limit | output | 32 | Loaded FS limit |
| gs_limit | output | 32 | Loaded GS limit |
| fs_attr | output | 14 | Loaded FS attribute word |
| gs_attr | output | 14 | Loaded GS attribute word |
| fs_sel | output | 16 | Loaded FS selector |
| gs_sel | output | 16 | Loaded GS selector |

## Verification
On every cycle the assertions check four things. The result strobe follows the request by one cycle. Descriptors stay frozen when no result or a faulting result arrives. An accepted non-wrapping 32-bit span never ends past the data segment limit. A 64-bit fault is never raised on two canonical bases. The exact arithmetic needs the bench's scenarios: modulo-2^32 bases, ends exactly at or one past the limit, wrap-around against a full and a nearly full data segment, and both sides of the canonical boundary. The same holds for the fixed and copied attribute bits.

// File: rtl/segbld_pkg.sv
package segbld_pkg;
  localparam int ADDR_W = 32;
  localparam int VA_W   = 64;
  localparam int LIN_W  = 48;
  localparam int ATTR_W = 14;
  localparam int SEL_W  = 16;
  localparam logic [SEL_W-1:0] LOAD_SEL  = 16'h000B;
  localparam logic [3:0]       LOAD_TYPE = 4'b0001;
  localparam logic [ADDR_W-1:0] FULL_SPAN = '1;

  // modulo-2^ADDR_W sum; carry is dropped on purpose
  function automatic logic [ADDR_W-1:0] wrap_add(input logic [ADDR_W-1:0] a,
                                                 input logic [ADDR_W-1:0] b);
    return a + b;
  endfunction

  // upper bits from LIN_W-1 to the top must all match
  function automatic logic is_canon(input logic [VA_W-1:0] va);
    logic [VA_W-LIN_W:0] top;
    top = va[VA_W-1:LIN_W-1];
    return (top == '0) || (top == '1);
  endfunction
endpackage

// File: rtl/seg_lane.sv
module seg_lane
  import segbld_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode64,
  input  logic [ADDR_W-1:0] encl_base,
  input  logic [ADDR_W-1:0] ofs,
  input  logic [ADDR_W-1:0] lim,
  input  logic [ADDR_W-1:0] ds_limit,
  input  logic [VA_W-1:0]   base64,
  output logic [VA_W-1:0]   base_out,
  output logic              lane_fault
);
  logic [ADDR_W-1:0] base32, end32;
  logic wrap, span_fault, canon_fault;

  always_comb begin
    base32      = wrap_add(ofs, encl_base);
    end32       = wrap_add(base32, lim);
    wrap        = end32 < base32;
    span_fault  = wrap ? (ds_limit != FULL_SPAN) : (end32 > ds_limit);
    canon_fault = !is_canon(base64);
    base_out    = mode64 ? base64 : {{(VA_W-ADDR_W){1'b0}}, base32};
    lane_fault  = mode64 ? canon_fault : span_fault;
  end

  // R3
  span_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode64 && !lane_fault && !wrap) |-> (end32 <= ds_limit));

  // R5
  no_spurious_canon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode64 && lane_fault) |->
      !((base64[VA_W-1:LIN_W-1] == '0) || ($countones(base64[VA_W-1:LIN_W-1]) == VA_W-LIN_W+1)));
endmodule

// File: rtl/desc_attr_pack.sv
module desc_attr_pack
  import segbld_pkg::*;
(
  input  logic              ds_w,
  input  logic [1:0]        ds_dpl,
  input  logic              ds_avl,
  input  logic              ds_l,
  output logic [ATTR_W-1:0] attr
);
  // [3:0] type [4] W [5] S [7:6] DPL [8] P [9] AVL [10] L [11] B [12] G [13] unusable
  always_comb begin
    attr        = '0;
    attr[3:0]   = LOAD_TYPE;
    attr[4]     = ds_w;
    attr[5]     = 1'b1;
    attr[7:6]   = ds_dpl;
    attr[8]     = 1'b1;
    attr[9]     = ds_avl;
    attr[10]    = ds_l;
    attr[11]    = 1'b1;
    attr[12]    = 1'b1;
    attr[13]    = 1'b0;
  end
endmodule

// File: rtl/seg_desc_builder.sv
module seg_desc_builder
  import segbld_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              mode64,
  input  logic [31:0]       encl_base,
  input  logic [31:0]       fs_ofs,
  input  logic [31:0]       gs_ofs,
  input  logic [31:0]       fs_lim,
  input  logic [31:0]       gs_lim,
  input  logic [31:0]       ds_limit,
  input  logic              ds_w,
  input  logic [1:0]        ds_dpl,
  input  logic              ds_avl,
  input  logic              ds_l,
  input  logic [63:0]       fs_base64,
  input  logic [63:0]       gs_base64,
  output logic              out_valid,
  output logic              fault,
  output logic [63:0]       fs_base,
  output logic [63:0]       gs_base,
  output logic [31:0]       fs_limit,
  output logic [31:0]       gs_limit,
  output logic [13:0]       fs_attr,
  output logic [13:0]       gs_attr,
  output logic [15:0]       fs_sel,
  output logic [15:0]       gs_sel
);
  localparam int NSEG = 2;

  logic [ADDR_W-1:0] ofs_a  [NSEG];
  logic [ADDR_W-1:0] lim_a  [NSEG];
  logic [VA_W-1:0]   b64_a  [NSEG];
  logic [VA_W-1:0]   base_a [NSEG];
  logic [NSEG-1:0]   lane_fault;
  logic [ATTR_W-1:0] new_attr;
  logic              any_fault, load_desc;

  assign ofs_a[0] = fs_ofs;    assign ofs_a[1] = gs_ofs;
  assign lim_a[0] = fs_lim;    assign lim_a[1] = gs_lim;
  assign b64_a[0] = fs_base64; assign b64_a[1] = gs_base64;

  genvar g;
  generate
    for (g = 0; g < NSEG; g++) begin : g_lane
      seg_lane u_lane (
        .clk(clk), .rst_n(rst_n), .mode64(mode64), .encl_base(encl_base),
        .ofs(ofs_a[g]), .lim(lim_a[g]), .ds_limit(ds_limit),
        .base64(b64_a[g]), .base_out(base_a[g]), .lane_fault(lane_fault[g])
      );
    end
  endgenerate

  desc_attr_pack u_attr (
    .ds_w(ds_w), .ds_dpl(ds_dpl), .ds_avl(ds_avl), .ds_l(ds_l), .attr(new_attr)
  );

  assign any_fault = |lane_fault;
  assign load_desc = in_valid && !any_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      fault     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) fault <= any_fault;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_base  <= '0; gs_base  <= '0;
      fs_limit <= '0; gs_limit <= '0;
      fs_attr  <= '0; gs_attr  <= '0;
      fs_sel   <= '0; gs_sel   <= '0;
    end else if (load_desc) begin
      fs_base  <= base_a[0]; gs_base  <= base_a[1];
      fs_limit <= fs_lim;    gs_limit <= gs_lim;
      fs_attr  <= new_attr;  gs_attr  <= new_attr;
      fs_sel   <= LOAD_SEL;  gs_sel   <= LOAD_SEL;
    end
  end

  // R1
  result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R1
  no_stray_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R10
  hold_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fault) |-> ($stable(fs_base) && $stable(gs_base) &&
                              $stable(fs_attr) && $stable(gs_limit)));

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(fs_base) && $stable(gs_sel) && $stable(fault)));
endmodule

// File: tb/tb_seg_desc_builder.sv
module tb_seg_desc_builder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, mode64 = 1'b0;
  logic [31:0] encl_base = '0, fs_ofs = '0, gs_ofs = '0, fs_lim = '0, gs_lim = '0, ds_limit = '0;
  logic ds_w = 1'b0, ds_avl = 1'b0, ds_l = 1'b0;
  logic [1:0] ds_dpl = '0;
  logic [63:0] fs_base64 = '0, gs_base64 = '0;
  logic out_valid, fault;
  logic [63:0] fs_base, gs_base;
  logic [31:0] fs_limit, gs_limit;
  logic [13:0] fs_attr, gs_attr;
  logic [15:0] fs_sel, gs_sel;

  int checks = 0, failures = 0;
  logic [63:0] e_fsb = '0, e_gsb = '0;
  logic [31:0] e_fsl = '0, e_gsl = '0;
  logic [13:0] e_attr = '0;
  logic [15:0] e_sel = '0;

  always #5 clk = ~clk;

  seg_desc_builder dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic span_bad(input logic [31:0] o, input logic [31:0] eb,
                                    input logic [31:0] l, input logic [31:0] dl);
    logic [32:0] s; logic [31:0] st, en;
    s = {1'b0, o} + {1'b0, eb}; st = s[31:0];
    s = {1'b0, st} + {1'b0, l};  en = s[31:0];
    if (en < st) return dl != 32'hFFFF_FFFF;   // R4 wrap case
    return en > dl;                               // R3
  endfunction

  function automatic logic not_canon(input logic [63:0] v);
    logic signed [63:0] sv;
    sv = $signed(v) >>> 47;
    return !(sv == 0 || sv == -1);               // R5
  endfunction

  task automatic apply(input logic m, input logic [31:0] eb, input logic [31:0] fo,
                       input logic [31:0] go, input logic [31:0] fl, input logic [31:0] gl,
                       input logic [31:0] dl, input logic [63:0] f64, input logic [63:0] g64);
    logic ef;
    logic [13:0] na;
    @(negedge clk);
    mode64 = m; encl_base = eb; fs_ofs = fo; gs_ofs = go; fs_lim = fl; gs_lim = gl;
    ds_limit = dl; fs_base64 = f64; gs_base64 = g64;
    ds_w = 1'($urandom); ds_avl = 1'($urandom); ds_l = 1'($urandom); ds_dpl = 2'($urandom);
    in_valid = 1'b1;
    if (m) ef = not_canon(f64) | not_canon(g64);
    else   ef = span_bad(fo, eb, fl, dl) | span_bad(go, eb, gl, dl);
    na = {1'b0, 1'b1, 1'b1, ds_l, ds_avl, 1'b1, ds_dpl, 1'b1, ds_w, 4'b0001};
    if (!ef) begin
      e_fsb = m ? f64 : {32'd0, fo + eb};
      e_gsb = m ? g64 : {32'd0, go + eb};
      e_fsl = fl; e_gsl = gl; e_attr = na; e_sel = 16'h000B;
    end
    @(negedge clk);
    in_valid = 1'b0;
    // R1 result one cycle later
    chk("R1 out_valid", {63'd0, out_valid}, 64'd1);
    chk("R3/R4/R5/R6 fault", {63'd0, fault}, {63'd0, ef});
    chk("R2/R5/R10 fs_base", fs_base, e_fsb);
    chk("R2/R5/R10 gs_base", gs_base, e_gsb);
    chk("R7/R10 fs_limit", {32'd0, fs_limit}, {32'd0, e_fsl});
    chk("R7/R10 gs_limit", {32'd0, gs_limit}, {32'd0, e_gsl});
    chk("R8/R9 fs_attr", {50'd0, fs_attr}, {50'd0, e_attr});
    chk("R8/R9 gs_attr", {50'd0, gs_attr}, {50'd0, e_attr});
    chk("R8 fs_sel", {48'd0, fs_sel}, {48'd0, e_sel});
    chk("R8 gs_sel", {48'd0, gs_sel}, {48'd0, e_sel});
    @(negedge clk);
    chk("R1 single pulse", {63'd0, out_valid}, 64'd0);
    chk("R1 hold fault", {63'd0, fault}, {63'd0, ef});
  endtask

  function automatic logic [63:0] rnd_va(input bit canon);
    logic [63:0] v;
    v = {$urandom, $urandom};
    if (canon) v[63:47] = v[47] ? '1 : '0;
    else if (v[63:47] == '0 || v[63:47] == '1) v[60] = ~v[60];
    return v;
  endfunction

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 out_valid", {63'd0, out_valid}, 0);
    chk("R11 fault", {63'd0, fault}, 0);
    chk("R11 fs_base", fs_base, 0);
    chk("R11 gs_attr", {50'd0, gs_attr}, 0);
    chk("R11 fs_sel", {48'd0, fs_sel}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle", {63'd0, out_valid}, 0);

    // R3 end exactly at limit accepted, one past faults (state holds: R10)
    apply(0, 32'h1000_0000, 32'h100, 32'h200, 32'hF00, 32'h10, 32'h1000_1000, 0, 0);
    apply(0, 32'h1000_0000, 32'h100, 32'h200, 32'hF01, 32'h10, 32'h1000_1000, 0, 0);
    // R2 base carry dropped, no fault from it
    apply(0, 32'hF000_0000, 32'h2000_0000, 32'h2000_0000, 32'h10, 32'h10, 32'h2000_0000, 0, 0);
    // R4 wrap with full data segment ok, nearly full faults
    apply(0, 32'hFFFF_0000, 32'h0, 32'h0, 32'h0002_0000, 32'h5, 32'hFFFF_FFFF, 0, 0);
    apply(0, 32'hFFFF_0000, 32'h0, 32'h0, 32'h0002_0000, 32'h5, 32'hFFFF_FFFE, 0, 0);
    // R6 64-bit bases ignored in 32-bit mode
    apply(0, 32'h10, 32'h20, 32'h30, 32'h40, 32'h50, 32'hFFFF, 64'h8000_0000_0000_0000, 64'h1234_0000_0000_0000);
    // R5 canonical boundaries
    apply(1, 0, 0, 0, 0, 0, 0, 64'h0000_7FFF_FFFF_FFFF, 64'hFFFF_8000_0000_0000);
    apply(1, 0, 0, 0, 0, 0, 0, 64'h0000_8000_0000_0000, 64'h0);
    apply(1, 0, 0, 0, 0, 0, 0, 64'h0, 64'hFFFF_7FFF_FFFF_FFFF);
    // R6 span inputs ignored in 64-bit mode (would fault in 32-bit mode)
    apply(1, 32'hFFFF_0000, 32'hFFFF, 32'hFFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 64'h42_0000, 64'hFFFF_FFFF_FFFF_F000);

    for (int i = 0; i < 400; i++) begin
      logic m;
      logic [31:0] dl;
      m  = ($urandom % 3) == 0;
      dl = (($urandom % 4) == 0) ? 32'hFFFF_FFFF : $urandom;
      apply(m, $urandom, $urandom >> ($urandom % 32), $urandom >> ($urandom % 32),
            $urandom >> ($urandom % 32), $urandom >> ($urandom % 32), dl,
            rnd_va(($urandom % 4) != 0), rnd_va(($urandom % 4) != 0));
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule